// File: doc/BRIEF.md
# UART Interrupt Identification and Priority

This block produces the interrupt identification byte and the single interrupt request line of a 16550-style UART. The rest of the UART sends it four kinds of event. A receiver line error covers overrun, parity, framing and break. A receive event means data is available or the FIFO trigger level has been reached. Each character-time tick and each receive FIFO push is also an input. The fourth event is the transmit holding register becoming empty. The block holds one pending flag per source. Each flag is cleared by its own bus side effect: a read of the line status register, a read of the receive buffer, a read of the identification register, or a write of the transmit holding register.

The pending sources are ranked in a fixed order and encoded into bits 3:0 of the identification byte. Bit 0 is an active-low "pending" flag. The top two bits mirror the FIFO-enable control bit. In FIFO mode the block also tracks the character timeout. A counter of character-time ticks restarts on every push or pop of the receive FIFO. It raises the timeout source when the FIFO is not empty and nothing has moved for `TO_CHARS` character times. All inputs are plain level or single-cycle strobe signals, sampled on the rising clock edge. The flags are registered, and the identification byte is a combinational function of the flags, the per-source enables and the FIFO-enable bit.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the identification byte reads 8'h01 and `irq_o` is 0.
- R2: Line status outranks everything. Received data outranks the timeout, which is at the same level. Transmit holding empty is lowest.
- R3: Bits 3:0 read 4'b0110 for line status, 4'b0100 for received data, 4'b1100 for character timeout, 4'b0010 for transmit holding empty, and 4'b0001 when nothing is enabled and pending.
- R4: Bits 7:6 read 2'b11 when `fifo_en_i` is 1 and 2'b00 otherwise. Bits 5:4 always read 0.
- R5: `irq_o` is the inverse of bit 0. A source whose `ien_i` bit is 0 does not contribute, but its flag is kept and appears once the bit is set. Enable bit order: [0] line status, [1] received data, [2] timeout, [3] transmit empty.
- R6: A `lsr_err_i` pulse sets the line status source. A `lsr_rd_i` strobe clears it.
- R7: A `rx_evt_i` pulse sets the received-data source. A `rbr_rd_i` strobe clears it. In FIFO mode it is also cleared while `rx_level_i` is below `rx_trig_i`.
- R8: In FIFO mode, with the FIFO non-empty and no push or pop, the `TO_CHARS`-th `char_tick_i` reports the timeout from the second edge after that tick. A `rbr_rd_i` strobe clears it. Bit 3 is never 1 with `fifo_en_i` at 0.
- R9: The timeout count restarts on `rx_push_i` or `rbr_rd_i`. It does not advance while the FIFO level is 0 or FIFO mode is off.
- R10: The transmit-empty source is set by `thr_empty_evt_i`. It is cleared by `thr_wr_i`, or by `iir_rd_i` only in a cycle where bits 3:0 report it. An identification read while another source is reported leaves it pending.
- R11: When a set and a clear of the same source arrive in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fifo_en_i | input | 1 | FIFO-enable control bit |
| ien_i | input | 4 | Per-source interrupt enables |
| lsr_err_i | input | 1 | Receiver line error event |
| rx_evt_i | input | 1 | Receive data available / trigger reached event |
| thr_empty_evt_i | input | 1 | Transmit holding register became empty |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_trig_i | input | LVL_W | Receive FIFO trigger level |
| rx_push_i | input | 1 | Character written into the receive FIFO |
| char_tick_i | input | 1 | One character time elapsed |
| lsr_rd_i | input | 1 | Line status register read strobe |
| rbr_rd_i | input | 1 | Receive buffer read strobe (FIFO pop) |
| iir_rd_i | input | 1 | Identification register read strobe |
| thr_wr_i | input | 1 | Transmit holding register write strobe |
| iir_o | output | 8 | Identification register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench targets the cases where a clear could reach the wrong source. The first is an identification read while received data hides a pending transmit-empty source. A design that clears on any read would lose that interrupt. The bench also drives a set and a clear into the same cycle. A clear-first design drops the new event. The timeout is probed one tick short of the limit, across a push that must restart the count, and in non-FIFO and empty-FIFO conditions. An off-by-one counter, or one that counts when it should hold, reports 4'b1100 in the wrong place. Masked sources are raised with enables off and then revealed, to show the flags survive masking. A FIFO level dropping under the trigger must retract the received-data source.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int N_SRC = 4;
  localparam int SRC_LS = 0;
  localparam int SRC_RX = 1;
  localparam int SRC_TO = 2;
  localparam int SRC_TX = 3;

  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_RX   = 4'b0100;
  localparam logic [3:0] ID_TO   = 4'b1100;
  localparam logic [3:0] ID_TX   = 4'b0010;
  localparam logic [3:0] ID_NONE = 4'b0001;
endpackage

// File: rtl/uart_irq_flag.sv
// Single pending flag: set has priority over clear in the same cycle.
module uart_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_tmo.sv
// Character timeout tracker: counts character ticks while the receive FIFO
// holds data and is idle; restarts on push or pop.
module uart_irq_tmo #(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic             tick_i,
  output logic             pend_o
);
  localparam int CNT_W = $clog2(TO_CHARS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TO_CHARS);

  logic [CNT_W-1:0] cnt_q;
  logic             restart;
  logic             hit;

  assign restart = !fifo_en_i || (rx_level_i == '0) || push_i || pop_i;
  assign hit     = (cnt_q == LIMIT);

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart)            cnt_q <= '0;
    else if (tick_i && !hit)     cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni)                 pend_o <= 1'b0;
    else if (pop_i || !fifo_en_i) pend_o <= 1'b0;
    else if (hit)                pend_o <= 1'b1;
  end
endmodule

// File: rtl/uart_irq_prio.sv
// Fixed-priority encoder from gated pending sources to the 4-bit identity.
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [N_SRC-1:0] pend_i,
  output logic [3:0]       id_o
);
  always_comb begin
    if (pend_i[SRC_LS])      id_o = ID_LS;
    else if (pend_i[SRC_RX]) id_o = ID_RX;
    else if (pend_i[SRC_TO]) id_o = ID_TO;
    else if (pend_i[SRC_TX]) id_o = ID_TX;
    else                     id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int LVL_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [3:0]       ien_i,
  input  logic             lsr_err_i,
  input  logic             rx_evt_i,
  input  logic             thr_empty_evt_i,
  input  logic [LVL_W-1:0] rx_level_i,
  input  logic [LVL_W-1:0] rx_trig_i,
  input  logic             rx_push_i,
  input  logic             char_tick_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  output logic [7:0]       iir_o,
  output logic             irq_o
);
  logic [N_SRC-1:0] set_v;
  logic [N_SRC-1:0] clr_v;
  logic [N_SRC-1:0] pend_raw;
  logic [N_SRC-1:0] pend_gated;
  logic [3:0]       id;

  always_comb begin
    set_v[SRC_LS] = lsr_err_i;
    clr_v[SRC_LS] = lsr_rd_i;
    set_v[SRC_RX] = rx_evt_i;
    clr_v[SRC_RX] = rbr_rd_i || (fifo_en_i && (rx_level_i < rx_trig_i));
    set_v[SRC_TO] = rx_push_i;
    clr_v[SRC_TO] = rbr_rd_i;
    set_v[SRC_TX] = thr_empty_evt_i;
    clr_v[SRC_TX] = thr_wr_i || (iir_rd_i && (id == ID_TX));
  end

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    if (g == SRC_TO) begin : g_tmo
      uart_irq_tmo #(.LVL_W(LVL_W), .TO_CHARS(TO_CHARS)) tmo_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .fifo_en_i (fifo_en_i),
        .rx_level_i(rx_level_i),
        .push_i    (set_v[g]),
        .pop_i     (clr_v[g]),
        .tick_i    (char_tick_i),
        .pend_o    (pend_raw[g])
      );
    end else begin : g_flag
      uart_irq_flag flag_i (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .set_i (set_v[g]),
        .clr_i (clr_v[g]),
        .q_o   (pend_raw[g])
      );
    end
  end

  always_comb begin
    pend_gated         = pend_raw & ien_i;
    pend_gated[SRC_TO] = pend_raw[SRC_TO] && ien_i[SRC_TO] && fifo_en_i;
  end

  uart_irq_prio prio_i (
    .pend_i(pend_gated),
    .id_o  (id)
  );

  assign iir_o = {{2{fifo_en_i}}, 2'b00, id};
  assign irq_o = ~id[0];
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       fifo_en_i,
  input logic [3:0] ien_i,
  input logic       lsr_err_i,
  input logic       lsr_rd_i,
  input logic       thr_empty_evt_i,
  input logic       thr_wr_i,
  input logic [7:0] iir_o,
  input logic       irq_o
);
  assert_ls_top_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_err_i |=> (!ien_i[0] || iir_o[3:0] == 4'b0110));

  assert_mask_all_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_i == 4'b0000) |-> !irq_o);

  assert_ls_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lsr_rd_i && !lsr_err_i) |=> (iir_o[3:0] != 4'b0110));

  assert_no_tmo_nofifo_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_i |-> !iir_o[3]);

  assert_thr_wr_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_wr_i && !thr_empty_evt_i) |=> (iir_o[3:0] != 4'b0010));
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .fifo_en_i      (fifo_en_i),
  .ien_i          (ien_i),
  .lsr_err_i      (lsr_err_i),
  .lsr_rd_i       (lsr_rd_i),
  .thr_empty_evt_i(thr_empty_evt_i),
  .thr_wr_i       (thr_wr_i),
  .iir_o          (iir_o),
  .irq_o          (irq_o)
);

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;
  localparam int LVL_W = 5;
  localparam int NV = 16;
  // [23:20] req, [19] fifo_en, [18:15] ien, [14] lsr_err, [13] rx_evt,
  // [12] thr_evt, [11] lsr_rd, [10] rbr_rd, [9] iir_rd, [8] thr_wr, [7:0] exp
  localparam logic [23:0] VEC [NV] = '{
    {4'd4,  1'b0, 4'hF, 7'b000_0000, 8'h01}, // R4 non-FIFO idle
    {4'd4,  1'b1, 4'hF, 7'b000_0000, 8'hC1}, // R4 FIFO idle
    {4'd10, 1'b0, 4'hF, 7'b001_0000, 8'h02}, // R10 tx empty raised
    {4'd2,  1'b0, 4'hF, 7'b010_0000, 8'h04}, // R2 rx over tx
    {4'd2,  1'b0, 4'hF, 7'b100_0000, 8'h06}, // R2 line status top
    {4'd6,  1'b0, 4'hF, 7'b000_1000, 8'h04}, // R6 lsr read clears
    {4'd10, 1'b0, 4'hF, 7'b000_0010, 8'h04}, // R10 iir read, rx reported
    {4'd7,  1'b0, 4'hF, 7'b000_0100, 8'h02}, // R7 rbr read; R10 tx kept
    {4'd10, 1'b0, 4'hF, 7'b000_0010, 8'h01}, // R10 iir read clears tx
    {4'd11, 1'b0, 4'hF, 7'b001_0001, 8'h02}, // R11 set beats clear
    {4'd10, 1'b0, 4'hF, 7'b000_0001, 8'h01}, // R10 thr write clears
    {4'd5,  1'b0, 4'h0, 7'b100_0000, 8'h01}, // R5 masked
    {4'd5,  1'b0, 4'h1, 7'b000_0000, 8'h06}, // R5 revealed
    {4'd11, 1'b0, 4'h1, 7'b100_1000, 8'h06}, // R11 ls set beats clear
    {4'd6,  1'b0, 4'h1, 7'b000_1000, 8'h01}, // R6 cleared
    {4'd3,  1'b1, 4'hF, 7'b010_0000, 8'hC4}  // R3 rx code in FIFO mode
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fifo_en = 1'b0;
  logic [3:0] ien = 4'h0;
  logic lsr_err = 0, rx_evt = 0, thr_evt = 0, push = 0, tick = 0;
  logic lsr_rd = 0, rbr_rd = 0, iir_rd = 0, thr_wr = 0;
  logic [LVL_W-1:0] level = '0;
  logic [LVL_W-1:0] trig = '0;
  logic [7:0] iir;
  logic irq;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  uart_irq_ident #(.LVL_W(LVL_W), .TO_CHARS(4)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .ien_i(ien),
    .lsr_err_i(lsr_err), .rx_evt_i(rx_evt), .thr_empty_evt_i(thr_evt),
    .rx_level_i(level), .rx_trig_i(trig), .rx_push_i(push),
    .char_tick_i(tick), .lsr_rd_i(lsr_rd), .rbr_rd_i(rbr_rd),
    .iir_rd_i(iir_rd), .thr_wr_i(thr_wr), .iir_o(iir), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] exp);
    checks++;
    if (iir !== exp || irq !== ~exp[0]) begin
      fails++;
      $display("FAIL %s iir=%h irq=%b expected iir=%h irq=%b", req, iir, irq, exp, ~exp[0]);
    end
  endtask

  task automatic clr_pulses();
    lsr_err = 0; rx_evt = 0; thr_evt = 0; push = 0; tick = 0;
    lsr_rd = 0; rbr_rd = 0; iir_rd = 0; thr_wr = 0;
  endtask

  task automatic step();
    @(posedge clk); #1;
    clr_pulses();
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step();
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_reset();
    rst_n = 0; step(); step(); rst_n = 1;
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    do_reset();
    check("R1", 8'h01);

    level = 5'd8; trig = 5'd4;
    for (int v = 0; v < NV; v++) begin
      fifo_en = VEC[v][19];
      ien     = VEC[v][18:15];
      lsr_err = VEC[v][14]; rx_evt = VEC[v][13]; thr_evt = VEC[v][12];
      lsr_rd  = VEC[v][11]; rbr_rd = VEC[v][10]; iir_rd  = VEC[v][9];
      thr_wr  = VEC[v][8];
      step();
      check($sformatf("R%0d vec%0d", VEC[v][23:20], v), VEC[v][7:0]);
    end

    // R1: reset clears the pending rx source left by the table
    do_reset();
    check("R1 mid-run", fifo_en ? 8'hC1 : 8'h01);

    // R7: FIFO level falling under trigger retracts rx source
    fifo_en = 1; ien = 4'hF; level = 5'd8; trig = 5'd4;
    rx_evt = 1; step();
    check("R7 rx set", 8'hC4);
    level = 5'd3; step();
    check("R7 level drop", 8'hC1);

    // R8: timeout after four ticks, one short reports nothing
    level = 5'd2; trig = 5'd8;
    ticks(3); idle(2);
    check("R8 three ticks", 8'hC1);
    ticks(1); idle(1);
    check("R8 timeout", 8'hCC);
    rbr_rd = 1; step();
    check("R8 rbr clears", 8'hC1);

    // R9: push restarts the count
    ticks(3); push = 1; step(); ticks(3); idle(2);
    check("R9 push restart", 8'hC1);
    ticks(1); idle(1);
    check("R9 after restart", 8'hCC);
    rbr_rd = 1; step();

    // R9: no counting in non-FIFO mode or with empty FIFO
    fifo_en = 0; ticks(6); idle(2);
    check("R9 non-FIFO", 8'h01);
    fifo_en = 1; level = 5'd0; ticks(6); idle(2);
    check("R9 empty", 8'hC1);

    // R2: rx outranks timeout at the same level
    level = 5'd2; trig = 5'd2;
    ticks(4); idle(1);
    check("R2 timeout alone", 8'hCC);
    rx_evt = 1; step();
    check("R2 rx over timeout", 8'hC4);
    rbr_rd = 1; step();
    check("R7 rbr clears both", 8'hC1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule